// File: doc/BRIEF.md
# Three-Mode Word-to-Byte Unpacker

This block sits between a memory-word source and a byte-wide print engine. It accepts 36-bit words one at a time on a valid/ready interface. It breaks each word into bytes, most significant byte first, and hands the bytes downstream one per valid/ready handshake. Three packings are supported. The narrow packing holds five left-justified 7-bit bytes per word. The wide packing holds four left-justified 8-bit bytes per word. The paired packing holds nine 8-bit bytes in two consecutive words, and one byte straddles the boundary between the two words.

A burst begins with the first word accepted while the block is idle. At that point the block samples the packing select and a byte limit. It emits exactly that many bytes and raises a last-byte marker on the final one, even when a word is only partly used. The next word accepted after that starts a new burst. The block does not generate addresses and does not count the whole transfer.

Top module: `word_byte_unpacker`

## Requirements
- R1: After reset, out_valid and out_last are low and in_ready is high.
- R2: Mode codes 2'b01 and 2'b00 both select the narrow packing. A word gives five bytes in this order: in_word[35:29], [28:22], [21:15], [14:8], [7:1]. Each byte appears on out_byte[6:0], out_byte[7] is zero, and in_word[0] is ignored.
- R3: Mode code 2'b10 selects the wide packing. A word gives four bytes in this order: in_word[35:28], [27:20], [19:12], [11:4]. in_word[3:0] is ignored.
- R4: Mode code 2'b11 selects the paired packing. The first word of a pair gives bytes as in R3. Its bits [3:0] are kept. The second word then gives five bytes: {first[3:0], second[35:32]}, then second[31:24], [23:16], [15:8], [7:0].
- R5: A burst emits exactly the byte limit sampled at its first word. out_last is high with the final byte only. A word that holds more bytes than remain is left after the bytes needed, and no further word is taken for that burst.
- R6: In the paired packing, when the byte limit ends on the straddling byte, the second word is still accepted, and that byte is emitted with out_last high.
- R7: A byte limit of zero means 2^CNT_W bytes, which is 1024 at the default width.
- R8: in_ready is low whenever out_valid is high. A word is taken only after the last needed byte of the previous word has been accepted downstream.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_byte and out_last keep their values.
- R10: Changes on mode or limit after the first word of a burst has been accepted have no effect until the burst ends.
- R11: out_valid rises in the cycle after a word is accepted, and out_valid falls in the cycle after the final byte of a word or burst is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Packing select, sampled at burst start |
| limit | input | CNT_W | Bytes in the burst, sampled at burst start (0 = 2^CNT_W) |
| in_valid | input | 1 | Word offered |
| in_word | input | WORD_W | Memory word, bit 35 most significant |
| in_ready | output | 1 | Word can be taken |
| out_valid | output | 1 | Byte offered downstream |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | BYTE_W | Unpacked byte |
| out_last | output | 1 | Final byte of the burst |

## Verification
Each word handshake must show up as a valid byte in the very next cycle, with in_ready low, and the bench checks that at the next falling edge. Every later byte can be checked in the cycle its handshake occurs, because out_byte and out_last come straight from registers. The bench drives inputs and samples outputs at the falling edge, and it predicts a handshake at the following rising edge from the values it has just sampled. The cycle after a final byte must show out_valid low; the bench checks this, and it checks that bytes stay unchanged under backpressure one cycle later.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
   typedef enum logic [1:0] {
      PK_NARROW_ALT = 2'b00,
      PK_NARROW     = 2'b01,
      PK_WIDE       = 2'b10,
      PK_PAIR       = 2'b11
   } pack_mode_e;
endpackage

// File: rtl/unpk_slicer.sv
module unpk_slicer
   import unpk_pkg::*;
#(
   parameter int WORD_W   = 36,
   parameter int BYTE_W   = 8,
   parameter int NARROW_W = 7,
   parameter int IDX_W    = 3
) (
   input  logic [WORD_W-1:0]         word_i,
   input  logic [WORD_W-(WORD_W/BYTE_W)*BYTE_W-1:0] nib_i,
   input  pack_mode_e                mode_i,
   input  logic                      phase_i,
   input  logic [IDX_W-1:0]          idx_i,
   output logic [BYTE_W-1:0]         byte_o
);
   localparam int N_NARROW  = WORD_W / NARROW_W;
   localparam int N_WIDE    = WORD_W / BYTE_W;
   localparam int SPLIT_W   = WORD_W - N_WIDE * BYTE_W;
   localparam int MAX_LANES = (N_NARROW > N_WIDE + 1) ? N_NARROW : N_WIDE + 1;

   initial begin
      a_split_half : assert (SPLIT_W * 2 == BYTE_W)
         else $error("straddling byte must be two equal halves");
      a_narrow_fits : assert (NARROW_W < BYTE_W)
         else $error("narrow byte must be shorter than the output byte");
   end

   logic [BYTE_W-1:0] narrow_l [MAX_LANES];
   logic [BYTE_W-1:0] wide_l   [MAX_LANES];
   logic [BYTE_W-1:0] second_l [MAX_LANES];

   for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
      if (g < N_NARROW) begin : g_nar
         assign narrow_l[g] = {{(BYTE_W-NARROW_W){1'b0}},
                               word_i[WORD_W-1-g*NARROW_W -: NARROW_W]};
      end else begin : g_nar_pad
         assign narrow_l[g] = '0;
      end
      if (g < N_WIDE) begin : g_wid
         assign wide_l[g] = word_i[WORD_W-1-g*BYTE_W -: BYTE_W];
      end else begin : g_wid_pad
         assign wide_l[g] = '0;
      end
      if (g == 0) begin : g_straddle
         assign second_l[g] = {nib_i, word_i[WORD_W-1 -: SPLIT_W]};
      end else if (g <= N_WIDE) begin : g_sec
         assign second_l[g] = word_i[WORD_W-1-SPLIT_W-(g-1)*BYTE_W -: BYTE_W];
      end else begin : g_sec_pad
         assign second_l[g] = '0;
      end
   end

   always_comb begin
      byte_o = '0;
      for (int k = 0; k < MAX_LANES; k++) begin
         if (idx_i == IDX_W'(k)) begin
            case (mode_i)
               PK_WIDE: byte_o = wide_l[k];
               PK_PAIR: byte_o = phase_i ? second_l[k] : wide_l[k];
               default: byte_o = narrow_l[k];
            endcase
         end
      end
   end
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
   import unpk_pkg::*;
#(
   parameter int CNT_W    = 10,
   parameter int N_NARROW = 5,
   parameter int N_WIDE   = 4,
   parameter int IDX_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             in_valid,
   input  logic             out_ready,
   output logic             in_ready,
   output logic             out_valid,
   output logic             out_last,
   output pack_mode_e       mode_q,
   output logic             phase_q,
   output logic [IDX_W-1:0] idx_q,
   output logic             ld_word,
   output logic             ld_nib
);
   logic             full_q, busy_q;
   logic [CNT_W-1:0] rem_q;
   logic [IDX_W-1:0] last_idx;
   logic             take_b, end_burst, end_word;

   always_comb begin
      case (mode_q)
         PK_WIDE: last_idx = IDX_W'(N_WIDE - 1);
         PK_PAIR: last_idx = phase_q ? IDX_W'(N_WIDE) : IDX_W'(N_WIDE - 1);
         default: last_idx = IDX_W'(N_NARROW - 1);
      endcase
   end

   assign in_ready  = !full_q;
   assign out_valid = full_q;
   assign out_last  = full_q && (rem_q == CNT_W'(1));
   assign ld_word   = in_valid && !full_q;
   assign take_b    = full_q && out_ready;
   assign end_burst = take_b && (rem_q == CNT_W'(1));
   assign end_word  = take_b && (idx_q == last_idx);
   assign ld_nib    = end_word && (mode_q == PK_PAIR) && !phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         busy_q  <= 1'b0;
         rem_q   <= '0;
         idx_q   <= '0;
         phase_q <= 1'b0;
         mode_q  <= PK_NARROW;
      end else if (ld_word) begin
         full_q <= 1'b1;
         idx_q  <= '0;
         if (!busy_q) begin
            busy_q  <= 1'b1;
            mode_q  <= pack_mode_e'(mode_i);
            rem_q   <= limit_i;
            phase_q <= 1'b0;
         end
      end else if (take_b) begin
         rem_q <= rem_q - CNT_W'(1);
         if (end_burst) begin
            full_q  <= 1'b0;
            busy_q  <= 1'b0;
            idx_q   <= '0;
            phase_q <= 1'b0;
         end else if (end_word) begin
            full_q <= 1'b0;
            idx_q  <= '0;
            if (mode_q == PK_PAIR) phase_q <= !phase_q;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   // R5 / R11: the final byte empties the holding stage
   p_last_empties_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (take_b && out_last) |=> (!out_valid && in_ready && !busy_q));
   // R10: burst settings frozen until the burst ends
   p_mode_frozen_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !end_burst) |=> $stable(mode_q));
   // R8: lane index never passes the word's last lane
   p_idx_bound_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (idx_q <= last_idx));
endmodule

// File: rtl/word_byte_unpacker.sv
module word_byte_unpacker
   import unpk_pkg::*;
#(
   parameter int WORD_W   = 36,
   parameter int BYTE_W   = 8,
   parameter int NARROW_W = 7,
   parameter int CNT_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [CNT_W-1:0]  limit,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_last
);
   localparam int N_NARROW  = WORD_W / NARROW_W;
   localparam int N_WIDE    = WORD_W / BYTE_W;
   localparam int SPLIT_W   = WORD_W - N_WIDE * BYTE_W;
   localparam int MAX_LANES = (N_NARROW > N_WIDE + 1) ? N_NARROW : N_WIDE + 1;
   localparam int IDX_W     = $clog2(MAX_LANES);

   logic [WORD_W-1:0]  word_q;
   logic [SPLIT_W-1:0] nib_q;
   pack_mode_e         mode_q;
   logic               phase_q, ld_word, ld_nib;
   logic [IDX_W-1:0]   idx_q;

   unpk_ctrl #(
      .CNT_W(CNT_W), .N_NARROW(N_NARROW), .N_WIDE(N_WIDE), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .limit_i(limit),
      .in_valid(in_valid), .out_ready(out_ready), .in_ready(in_ready),
      .out_valid(out_valid), .out_last(out_last), .mode_q(mode_q),
      .phase_q(phase_q), .idx_q(idx_q), .ld_word(ld_word), .ld_nib(ld_nib)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         nib_q  <= '0;
      end else begin
         if (ld_word) word_q <= in_word;
         if (ld_nib)  nib_q  <= word_q[SPLIT_W-1:0];
      end
   end

   unpk_slicer #(
      .WORD_W(WORD_W), .BYTE_W(BYTE_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
   ) u_slicer (
      .word_i(word_q), .nib_i(nib_q), .mode_i(mode_q), .phase_i(phase_q),
      .idx_i(idx_q), .byte_o(out_byte)
   );

   // R9: byte held under backpressure
   p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));
   // R11: a taken word yields a byte next cycle
   p_word_to_byte_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !in_ready));
   // R2: narrow bytes keep the top bit clear
   p_narrow_msb_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (mode_q == PK_NARROW || mode_q == PK_NARROW_ALT)) |-> !out_byte[BYTE_W-1]);
endmodule

// File: tb/word_byte_unpacker_test.sv
module word_byte_unpacker_test;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 10;
   localparam int NV = 10;

   localparam logic [35:0] WA = 36'h9A3C5E7F1;
   localparam logic [35:0] WB = 36'h6B2D4F80E;
   localparam logic [35:0] WC = 36'hFFFFFFFFF;
   localparam logic [35:0] WD = 36'h00000000F;

   // stimulus: mode, limit, word pair, backpressure; expected: byte count
   localparam int          T_MODE [NV] = '{1, 0, 2, 2, 3, 3, 3, 3, 1, 2};
   localparam int          T_LIM  [NV] = '{10, 7, 8, 6, 9, 5, 4, 20, 1, 0};
   localparam logic [35:0] T_W0   [NV] = '{WA, WA, WC, WA, WA, WB, WA, WB, WC, WA};
   localparam logic [35:0] T_W1   [NV] = '{WB, WB, WD, WB, WB, WA, WB, WA, WD, WB};
   localparam int          T_BP   [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
   localparam int          T_NB   [NV] = '{10, 7, 8, 6, 9, 5, 4, 20, 1, 1024};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode = 2'b01;
   logic [CNT_W-1:0] limit = '0;
   logic in_valid = 1'b0;
   logic [35:0] in_word = '0;
   logic in_ready, out_valid, out_last;
   logic out_ready = 1'b0;
   logic [7:0] out_byte;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   word_byte_unpacker #(.CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .limit(limit),
      .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
      .out_last(out_last)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(int m, logic [35:0] w0, logic [35:0] w1, int j);
      logic [35:0] w;
      int l;
      if (m == 2) begin
         w = ((j / 4) % 2 == 1) ? w1 : w0;
         l = j % 4;
         return 8'(w >> (28 - 8 * l));
      end else if (m == 3) begin
         l = j % 9;
         if (l < 4) return 8'(w0 >> (28 - 8 * l));
         if (l == 4) return {w0[3:0], w1[35:32]};
         return 8'(w1 >> (24 - 8 * (l - 5)));
      end
      w = ((j / 5) % 2 == 1) ? w1 : w0;
      l = j % 5;
      return {1'b0, 7'(w >> (29 - 7 * l))};
   endfunction

   function automatic int words_for(int m, int nb);
      if (m == 2) return (nb + 3) / 4;
      if (m == 3) return 2 * (nb / 9) + ((nb % 9 == 0) ? 0 : ((nb % 9 <= 4) ? 1 : 2));
      return (nb + 4) / 5;
   endfunction

   task automatic run_vec(input int v);
      int nb = T_NB[v];
      int nw = words_for(T_MODE[v], nb);
      int k = 0, wi = 0, cyc = 0;
      logic [7:0] prev_b = '0;
      logic prev_l = 1'b0;
      bit prev_hold = 0, acc_prev = 0, bad_byte = 0, bad_last = 0;
      while (k < nb && cyc < 6000) begin
         @(negedge clk);
         cyc++;
         if (prev_hold) // R9
            check(out_valid && out_byte == prev_b && out_last == prev_l, "R9 hold", out_byte, prev_b);
         if (acc_prev) // R11
            check(out_valid && !in_ready, "R11 byte after word", out_valid, 1);
         if (out_valid) // R8
            check(!in_ready, "R8 ready while byte pending", in_ready, 0);
         out_ready = (T_BP[v] == 1) ? (cyc % 3 != 0) : 1'b1;
         if (wi > 0) begin // R10: disturb settings mid-burst
            mode  = ~2'(T_MODE[v]);
            limit = CNT_W'(3);
         end else begin
            mode  = 2'(T_MODE[v]);
            limit = CNT_W'(T_LIM[v]);
         end
         in_valid = (wi < nw);
         in_word  = (wi % 2 == 1) ? T_W1[v] : T_W0[v];
         acc_prev = in_valid && in_ready;
         if (acc_prev) wi++;
         if (out_valid && out_ready) begin
            // R2 R3 R4 R6 R7 byte contents, R5 last marker
            if (out_byte !== exp_byte(T_MODE[v], T_W0[v], T_W1[v], k)) begin
               if (!bad_byte)
                  check(0, $sformatf("R2/R3/R4 vec %0d byte %0d", v, k), out_byte,
                        exp_byte(T_MODE[v], T_W0[v], T_W1[v], k));
               bad_byte = 1;
            end
            if (out_last !== (k == nb - 1)) begin
               if (!bad_last) check(0, $sformatf("R5 last vec %0d byte %0d", v, k), out_last, k == nb - 1);
               bad_last = 1;
            end
            k++;
         end
         prev_hold = out_valid && !out_ready;
         prev_b = out_byte;
         prev_l = out_last;
      end
      check(!bad_byte, $sformatf("R2 R3 R4 bytes vec %0d", v), bad_byte, 0);
      check(!bad_last, $sformatf("R5 R6 marker vec %0d", v), bad_last, 0);
      @(negedge clk);
      in_valid = 1'b0;
      check(!out_valid && in_ready, "R11 idle after final byte", out_valid, 0);
      check(k == nb, $sformatf("R5 R7 byte count vec %0d", v), k, nb);
      check(wi == nw, $sformatf("R5 R10 word count vec %0d", v), wi, nw);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!out_valid && !out_last && in_ready, "R1 reset state", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R1 after release", in_ready, 1);
      for (int v = 0; v < NV; v++) run_vec(v);
      // R1: reset mid-word empties the stage
      mode = 2'b10; limit = CNT_W'(8); in_word = WA; in_valid = 1'b1; out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid, "R11 directed word taken", out_valid, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(!out_valid && in_ready, "R1 reset mid-burst", out_valid, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule